// File: doc/BRIEF.md
# Ethernet Receive Ring Buffer Writer

This block accepts received Ethernet frames as a byte stream and writes them into a circular packet memory through a byte-wide write port. A six-byte header goes in front of each stored frame. The header holds a link to the following packet and a status word that carries the frame length. Packets always begin on an even address, so a pad byte is skipped after an odd-length frame. The host sees a packet only after the header has been written. At that point the hardware write pointer moves to the next packet and a pending-packet counter goes up by one.

The block checks free space against the host read pointer as each byte arrives. A frame that does not fit is dropped and raises a sticky receive-error flag. A frame that ends with the stream error marker leaves no trace: no flag, no count and no pointer change. Dropping the receive enable in the middle of a frame also discards it. A start-of-frame that arrives while a header is being written is ignored together with the rest of that frame. The host decrements the counter with a strobe after it has consumed a packet. A single interrupt output combines the packet-pending and error conditions under their individual enables and a global enable.

Top module: `eth_rx_ring_writer`

## Requirements
- R1: After reset the memory write strobe is low, the pending count is 0, and the packet flag, error flag and interrupt are all low.
- R2: While the receive enable is low, the write pointer equals the ring start address.
- R3: Frame bytes are written in arrival order. The first byte goes to packet start + 6. Addresses step from the ring end address back to the ring start address, and no write falls outside the ring.
- R4: The header sits at the packet start. Bytes 0 and 1 hold the next-packet address, low byte first, with unused upper bits zero. Bytes 2 to 5 hold the 32-bit status, least significant byte first. Status bits [15:0] are the frame length including CRC, bit 16 is 1 when the length is odd, bit 23 is 1, and all other status bits are 0.
- R5: The next-packet address is packet start + 6 + length, plus 1 when the length is odd, wrapped within the ring. With an even ring start, every packet start is even.
- R6: Only after all six header bytes have been written does the write pointer move to the next-packet address and the pending count rise by 1. Neither changes while a frame is still in progress.
- R7: A decrement strobe lowers the pending count by 1 and has no effect when the count is 0. The packet flag is high exactly when the count is nonzero.
- R8: Free space is the number of ring bytes from the write pointer up to the host read pointer, minus one; equal pointers mean an empty ring. A frame is stored only if 6 + its padded length is at most the free space. Otherwise it is dropped, the write pointer and count stay unchanged, and the error flag is set. The error flag holds until the clear input is pulsed.
- R9: A frame whose last byte carries the stream error marker is discarded with no change to the write pointer, the count or the error flag.
- R10: The interrupt equals global enable AND ((packet enable AND packet flag) OR (error enable AND error flag)).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receive enable |
| ring_start | input | AW | First address of the ring |
| ring_end | input | AW | Last address of the ring |
| host_rd_ptr | input | AW | Host read pointer |
| cnt_dec | input | 1 | Pending-count decrement strobe |
| pkt_ie | input | 1 | Packet interrupt enable |
| err_ie | input | 1 | Error interrupt enable |
| glob_ie | input | 1 | Global interrupt enable |
| err_clr | input | 1 | Clears the error flag |
| s_valid | input | 1 | Stream byte valid |
| s_sof | input | 1 | Marks the first byte of a frame |
| s_eof | input | 1 | Marks the last byte of a frame |
| s_err | input | 1 | Frame error, sampled with the last byte |
| s_data | input | 8 | Stream byte |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | AW | Memory write address |
| mem_wdata | output | 8 | Memory write data |
| wr_ptr | output | AW | Committed hardware write pointer |
| pkt_count | output | CW | Pending packet count |
| pkt_flag | output | 1 | Packet pending flag |
| err_flag | output | 1 | Receive overflow error flag |
| irq | output | 1 | Interrupt request |

## Verification
Directed frames of even, odd and single-byte length check the pad rule and the header fields. A frame of exactly the largest length that fits, and one a byte longer, sit on either side of the space limit. Holding the read pointer still until a frame is dropped shows whether the error flag, the count and the pointer separate a drop from a commit. A long run of frames with random lengths and random consumption makes packets straddle the ring end, which tells a correct wrap apart from an off-by-one. Errored frames and all combinations of the interrupt enables check that discards stay silent and that the interrupt is gated correctly.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_DATA, ST_HDR} rxr_state_e;
  localparam int unsigned HDR_BYTES = 6;
  localparam int unsigned LEN_W     = 16;
  localparam logic [7:0]  STAT_OK   = 8'h80;
endpackage

// File: rtl/rxr_ring_add.sv
module rxr_ring_add #(
  parameter int unsigned AW = 13
) (
  input  logic [AW-1:0] a,
  input  logic [AW:0]   k,
  input  logic [AW-1:0] lo,
  input  logic [AW-1:0] hi,
  output logic [AW-1:0] y
);
  logic [AW:0] ring_len;
  logic [AW:0] sum;

  always_comb begin
    ring_len = {1'b0, hi} - {1'b0, lo} + 1'b1;
    sum      = {1'b0, a} + k;
    if (sum > {1'b0, hi}) sum = sum - ring_len;
    y = sum[AW-1:0];
  end
endmodule

// File: rtl/rxr_space.sv
module rxr_space #(
  parameter int unsigned AW = 13
) (
  input  logic [AW-1:0] wr,
  input  logic [AW-1:0] rd,
  input  logic [AW-1:0] lo,
  input  logic [AW-1:0] hi,
  output logic [AW:0]   free
);
  logic [AW:0] ring_len;
  logic [AW:0] gap;

  always_comb begin
    ring_len = {1'b0, hi} - {1'b0, lo} + 1'b1;
    if (rd >= wr) gap = {1'b0, rd} - {1'b0, wr};
    else          gap = {1'b0, rd} + ring_len - {1'b0, wr};
    free = (gap == '0) ? ring_len - 1'b1 : gap - 1'b1;
  end
endmodule

// File: rtl/rxr_pktcnt.sv
module rxr_pktcnt #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          dec,
  output logic [CW-1:0] count,
  output logic          nonzero
);
  localparam logic [CW-1:0] CNT_MAX = '1;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_inc, do_dec;

  always_comb begin
    do_inc = inc && (cnt_q != CNT_MAX);
    do_dec = dec && (cnt_q != '0);
    cnt_d  = cnt_q;
    if (do_inc && !do_dec)      cnt_d = cnt_q + 1'b1;
    else if (do_dec && !do_inc) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count   = cnt_q;
  assign nonzero = (cnt_q != '0);
endmodule

// File: rtl/eth_rx_ring_writer.sv
module eth_rx_ring_writer
  import rxr_pkg::*;
#(
  parameter int unsigned AW = 13,
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_en,
  input  logic [AW-1:0] ring_start,
  input  logic [AW-1:0] ring_end,
  input  logic [AW-1:0] host_rd_ptr,
  input  logic          cnt_dec,
  input  logic          pkt_ie,
  input  logic          err_ie,
  input  logic          glob_ie,
  input  logic          err_clr,
  input  logic          s_valid,
  input  logic          s_sof,
  input  logic          s_eof,
  input  logic          s_err,
  input  logic [7:0]    s_data,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  output logic [AW-1:0] wr_ptr,
  output logic [CW-1:0] pkt_count,
  output logic          pkt_flag,
  output logic          err_flag,
  output logic          irq
);
  localparam int unsigned CMP_W = LEN_W + 2;

  rxr_state_e       state_q, state_d;
  logic [AW-1:0]    cur_q, cur_d;
  logic [LEN_W-1:0] n_q, n_d;
  logic             ovf_q, ovf_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic [AW-1:0]    nxt_q, nxt_d;
  logic [2:0]       hcnt_q, hcnt_d;
  logic [AW-1:0]    wr_q, wr_d;
  logic             we_q, we_d;
  logic [AW-1:0]    addr_q, addr_d;
  logic [7:0]       wdat_q, wdat_d;
  logic             err_q, err_d;

  logic [AW:0]      free;
  logic [AW-1:0]    base6, data_next, hdr_addr, pkt_next;
  logic             first, inb, take, fits, ovf_now, ok, space_drop, commit;
  logic [LEN_W-1:0] idx, len_now;
  logic [AW-1:0]    baddr;
  logic [CMP_W-1:0] need, tot, free_w;
  logic [15:0]      nxt16;
  logic [7:0]       hdr_byte;

  rxr_space #(.AW(AW)) u_space (
    .wr(wr_q), .rd(host_rd_ptr), .lo(ring_start), .hi(ring_end), .free(free));

  rxr_ring_add #(.AW(AW)) u_add_base (
    .a(wr_q), .k((AW+1)'(HDR_BYTES)), .lo(ring_start), .hi(ring_end), .y(base6));
  rxr_ring_add #(.AW(AW)) u_add_data (
    .a(baddr), .k((AW+1)'(1)), .lo(ring_start), .hi(ring_end), .y(data_next));
  rxr_ring_add #(.AW(AW)) u_add_hdr (
    .a(wr_q), .k((AW+1)'(hcnt_q)), .lo(ring_start), .hi(ring_end), .y(hdr_addr));
  rxr_ring_add #(.AW(AW)) u_add_next (
    .a(wr_q), .k(tot[AW:0]), .lo(ring_start), .hi(ring_end), .y(pkt_next));

  // Byte acceptance, space test and end-of-frame decision
  always_comb begin
    first      = (state_q == ST_IDLE) && rx_en && s_valid && s_sof;
    inb        = (state_q == ST_DATA) && rx_en && s_valid;
    take       = first || inb;
    idx        = first ? '0 : n_q;
    baddr      = first ? base6 : cur_q;
    free_w     = CMP_W'(free);
    need       = CMP_W'(idx) + CMP_W'(HDR_BYTES + 1);
    fits       = (need <= free_w);
    ovf_now    = (first ? 1'b0 : ovf_q) || !fits;
    len_now    = idx + 1'b1;
    tot        = CMP_W'(HDR_BYTES) + CMP_W'(len_now) + CMP_W'(len_now[0]);
    ok         = take && s_eof && !ovf_now && !s_err && (tot <= free_w);
    space_drop = take && s_eof && !s_err && !ok;
    commit     = (state_q == ST_HDR) && (hcnt_q == 3'd6) && rx_en;
  end

  // Header byte selection
  always_comb begin
    nxt16 = 16'(nxt_q);
    case (hcnt_q)
      3'd0:    hdr_byte = nxt16[7:0];
      3'd1:    hdr_byte = nxt16[15:8];
      3'd2:    hdr_byte = len_q[7:0];
      3'd3:    hdr_byte = len_q[15:8];
      3'd4:    hdr_byte = STAT_OK | {7'd0, len_q[0]};
      default: hdr_byte = 8'h00;
    endcase
  end

  // Next state
  always_comb begin
    state_d = state_q;
    cur_d   = cur_q;
    n_d     = n_q;
    ovf_d   = ovf_q;
    len_d   = len_q;
    nxt_d   = nxt_q;
    hcnt_d  = hcnt_q;
    we_d    = 1'b0;
    addr_d  = addr_q;
    wdat_d  = wdat_q;

    if (take) begin
      cur_d = data_next;
      n_d   = len_now;
      ovf_d = ovf_now;
      if (fits) begin
        we_d   = 1'b1;
        addr_d = baddr;
        wdat_d = s_data;
      end
    end

    case (state_q)
      ST_IDLE: if (first) state_d = s_eof ? (ok ? ST_HDR : ST_IDLE) : ST_DATA;
      ST_DATA: begin
        if (!rx_en)             state_d = ST_IDLE;
        else if (inb && s_eof)  state_d = ok ? ST_HDR : ST_IDLE;
      end
      ST_HDR: begin
        if (hcnt_q == 3'd6) begin
          state_d = ST_IDLE;
        end else begin
          we_d   = 1'b1;
          addr_d = hdr_addr;
          wdat_d = hdr_byte;
          hcnt_d = hcnt_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase

    if (ok) begin
      len_d  = len_now;
      nxt_d  = pkt_next;
      hcnt_d = '0;
    end

    if (!rx_en)      wr_d = ring_start;
    else if (commit) wr_d = nxt_q;
    else             wr_d = wr_q;

    err_d = space_drop || (err_q && !err_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
      n_q     <= '0;
      ovf_q   <= 1'b0;
      len_q   <= '0;
      nxt_q   <= '0;
      hcnt_q  <= '0;
      wr_q    <= '0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdat_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cur_q   <= cur_d;
      n_q     <= n_d;
      ovf_q   <= ovf_d;
      len_q   <= len_d;
      nxt_q   <= nxt_d;
      hcnt_q  <= hcnt_d;
      wr_q    <= wr_d;
      we_q    <= we_d;
      addr_q  <= addr_d;
      wdat_q  <= wdat_d;
      err_q   <= err_d;
    end
  end

  rxr_pktcnt #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc(commit), .dec(cnt_dec),
    .count(pkt_count), .nonzero(pkt_flag));

  assign mem_we    = we_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = wdat_q;
  assign wr_ptr    = wr_q;
  assign err_flag  = err_q;
  assign irq       = glob_ie && ((pkt_ie && pkt_flag) || (err_ie && err_q));
endmodule

// File: rtl/rxr_checker.sv
module rxr_checker #(
  parameter int unsigned AW = 13,
  parameter int unsigned CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_en,
  input logic [AW-1:0] ring_start,
  input logic [AW-1:0] ring_end,
  input logic          cnt_dec,
  input logic          glob_ie,
  input logic          err_clr,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [AW-1:0] wr_ptr,
  input logic [CW-1:0] pkt_count,
  input logic          err_flag,
  input logic          irq
);
  localparam logic [CW-1:0] CMAX = '1;

  assert_write_in_ring_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr >= ring_start && mem_addr <= ring_end));

  assert_even_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && !ring_start[0]) |-> !wr_ptr[0]);

  assert_count_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pkt_count == $past(pkt_count) || pkt_count == $past(pkt_count) + 1'b1 ||
              pkt_count == $past(pkt_count) - 1'b1));

  assert_commit_counts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && $past(rx_en) && wr_ptr != $past(wr_ptr) && !$past(cnt_dec) &&
     $past(pkt_count) != CMAX) |-> pkt_count == $past(pkt_count) + 1'b1);

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !err_clr) |=> err_flag);

  assert_irq_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> glob_ie);
endmodule

bind eth_rx_ring_writer rxr_checker #(.AW(AW), .CW(CW)) u_rxr_checker (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .ring_start(ring_start),
  .ring_end(ring_end), .cnt_dec(cnt_dec), .glob_ie(glob_ie), .err_clr(err_clr),
  .mem_we(mem_we), .mem_addr(mem_addr), .wr_ptr(wr_ptr), .pkt_count(pkt_count),
  .err_flag(err_flag), .irq(irq));

// File: tb/eth_rx_ring_writer_bench.sv
`timescale 1ns/1ps
module eth_rx_ring_writer_bench;
  localparam int AW    = 10;
  localparam int CW    = 8;
  localparam int RSTART = 32;
  localparam int REND   = 255;
  localparam int RLEN   = REND - RSTART + 1;

  logic clk = 1'b0;
  logic rst_n;
  logic rx_en, cnt_dec, pkt_ie, err_ie, glob_ie, err_clr;
  logic s_valid, s_sof, s_eof, s_err;
  logic [7:0] s_data;
  logic [AW-1:0] ring_start, ring_end, host_rd_ptr;
  logic mem_we;
  logic [AW-1:0] mem_addr, wr_ptr;
  logic [7:0] mem_wdata;
  logic [CW-1:0] pkt_count;
  logic pkt_flag, err_flag, irq;

  int checks = 0;
  int failures = 0;
  int ew, ecnt, rd;
  bit eerr;
  logic [7:0] mem [0:(1<<AW)-1];
  logic [7:0] fr [0:511];

  always #2 clk = ~clk;

  eth_rx_ring_writer #(.AW(AW), .CW(CW)) u_eth_rx_ring_writer (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .ring_start(ring_start),
    .ring_end(ring_end), .host_rd_ptr(host_rd_ptr), .cnt_dec(cnt_dec),
    .pkt_ie(pkt_ie), .err_ie(err_ie), .glob_ie(glob_ie), .err_clr(err_clr),
    .s_valid(s_valid), .s_sof(s_sof), .s_eof(s_eof), .s_err(s_err), .s_data(s_data),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .wr_ptr(wr_ptr),
    .pkt_count(pkt_count), .pkt_flag(pkt_flag), .err_flag(err_flag), .irq(irq));

  always @(negedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

  function automatic int wadd(int a, int k);
    int s = a + k;
    if (s > REND) s = s - RLEN;
    return s;
  endfunction

  function automatic int free_now(int w, int r);
    int d = (r >= w) ? r - w : r + RLEN - w;
    return (d == 0) ? RLEN - 1 : d - 1;
  endfunction

  function automatic bit exp_irq();
    return glob_ie && ((pkt_ie && ecnt != 0) || (err_ie && eerr));
  endfunction

  task automatic chk(bit good, string req, int act, int exp);
    checks++;
    if (!good) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(int len, bit err);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      s_valid = 1'b1; s_sof = (i == 0); s_eof = (i == len - 1);
      s_err = err && (i == len - 1); s_data = fr[i];
    end
    @(negedge clk);
    s_valid = 1'b0; s_sof = 1'b0; s_eof = 1'b0; s_err = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  task automatic frame(int len, bit err);
    int fb, padded, nxt, bad;
    for (int i = 0; i < len; i++) fr[i] = 8'($urandom);
    fb = free_now(ew, rd);
    send(len, err);
    padded = len + (len % 2);
    if (err) begin
      chk(int'(wr_ptr) == ew, "R9 wr_ptr after errored frame", int'(wr_ptr), ew);
      chk(int'(pkt_count) == ecnt, "R9 count after errored frame", int'(pkt_count), ecnt);
      chk(err_flag == eerr, "R9 error flag after errored frame", err_flag, eerr);
    end else if (6 + padded <= fb) begin
      nxt = wadd(ew, 6 + padded);
      chk(mem[ew] == 8'(nxt) && mem[wadd(ew,1)] == 8'(nxt >> 8), "R4 next-pointer bytes",
          int'({mem[wadd(ew,1)], mem[ew]}), nxt);
      chk(mem[wadd(ew,2)] == 8'(len) && mem[wadd(ew,3)] == 8'(len >> 8), "R4 length field",
          int'({mem[wadd(ew,3)], mem[wadd(ew,2)]}), len);
      chk(mem[wadd(ew,4)] == (8'h80 | 8'(len % 2)) && mem[wadd(ew,5)] == 8'h00,
          "R4 status upper bytes", int'({mem[wadd(ew,5)], mem[wadd(ew,4)]}),
          int'(16'h0080 | 16'(len % 2)));
      bad = 0;
      for (int i = 0; i < len; i++) if (mem[wadd(ew, 6 + i)] !== fr[i]) bad++;
      chk(bad == 0, "R3 frame bytes in order with wrap", bad, 0);
      ew = nxt; ecnt++;
      chk(int'(wr_ptr) == ew, "R5 R6 write pointer after commit", int'(wr_ptr), ew);
      chk(int'(pkt_count) == ecnt, "R6 count after commit", int'(pkt_count), ecnt);
      chk(pkt_flag == 1'b1, "R7 packet flag with pending packets", pkt_flag, 1);
    end else begin
      eerr = 1'b1;
      chk(err_flag == 1'b1, "R8 error flag on drop", err_flag, 1);
      chk(int'(wr_ptr) == ew, "R8 wr_ptr unchanged on drop", int'(wr_ptr), ew);
      chk(int'(pkt_count) == ecnt, "R8 count unchanged on drop", int'(pkt_count), ecnt);
    end
    chk(irq == exp_irq(), "R10 interrupt", irq, exp_irq());
  endtask

  task automatic consume();
    @(negedge clk);
    rd = ew; host_rd_ptr = AW'(rd);
    for (int i = 0; i < ecnt; i++) begin
      cnt_dec = 1'b1; @(negedge clk);
    end
    cnt_dec = 1'b0; ecnt = 0;
    @(negedge clk);
    chk(pkt_count == 0 && pkt_flag == 1'b0, "R7 count after decrements", int'(pkt_count), 0);
  endtask

  task automatic clear_err();
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0; eerr = 1'b0;
    @(negedge clk);
    chk(err_flag == 1'b0, "R8 error flag cleared", err_flag, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; rx_en = 1'b0; cnt_dec = 1'b0; pkt_ie = 1'b1; err_ie = 1'b0;
    glob_ie = 1'b1; err_clr = 1'b0; s_valid = 1'b0; s_sof = 1'b0; s_eof = 1'b0;
    s_err = 1'b0; s_data = 8'h00;
    ring_start = AW'(RSTART); ring_end = AW'(REND); host_rd_ptr = AW'(RSTART);
    ew = RSTART; rd = RSTART; ecnt = 0; eerr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mem_we == 1'b0 && pkt_count == 0 && !pkt_flag && !err_flag && !irq,
        "R1 reset state", int'({mem_we, pkt_flag, err_flag, irq}), 0);
    chk(int'(wr_ptr) == RSTART, "R2 pointer follows ring start while disabled",
        int'(wr_ptr), RSTART);
    rx_en = 1'b1;
    @(negedge clk);

    frame(60, 1'b0);   // even length
    frame(61, 1'b0);   // odd length, pad skipped
    frame(1, 1'b0);    // single byte
    frame(40, 1'b1);   // errored, silent discard

    // Fill without consuming until a drop occurs
    for (int i = 0; i < 8; i++) frame(30 + 7 * i, 1'b0);
    chk(eerr == 1'b1, "R8 ring filled to a drop", eerr, 1);
    pkt_ie = 1'b0; err_ie = 1'b1; glob_ie = 1'b1; @(negedge clk);
    chk(irq == 1'b1, "R10 error interrupt enabled", irq, 1);
    glob_ie = 1'b0; @(negedge clk);
    chk(irq == 1'b0, "R10 global enable off", irq, 0);
    glob_ie = 1'b1; pkt_ie = 1'b1;
    clear_err();
    consume();
    cnt_dec = 1'b1; @(negedge clk); cnt_dec = 1'b0; @(negedge clk);
    chk(pkt_count == 0, "R7 decrement at zero ignored", int'(pkt_count), 0);

    // Exact fit and one byte over (free is RLEN-1 after full consume)
    frame(RLEN - 7 - ((RLEN - 7) % 2), 1'b0);
    consume();
    frame(RLEN - 6, 1'b0);
    clear_err();

    // Random frames with random consumption
    for (int i = 0; i < 60; i++) begin
      frame(1 + int'($urandom_range(0, 119)), ($urandom_range(0, 7) == 0));
      if (eerr) clear_err();
      if ($urandom_range(0, 2) == 0) consume();
    end
    consume();

    rx_en = 1'b0;
    repeat (2) @(negedge clk);
    chk(int'(wr_ptr) == RSTART, "R2 pointer returns to ring start", int'(wr_ptr), RSTART);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule